// File: doc/BRIEF.md
# Program ROM Bank Mapper

This block sits between a cartridge CPU bus and its program ROM and RAM. It looks at the 16-bit CPU address and produces three things: the upper ROM address bits, which select an 8 KiB bank; a ROM chip enable; and a RAM chip enable. The low 13 address bits go to the ROM unchanged. Only two of the four 8 KiB ROM windows can be switched, and one mode bit decides which of the two lower windows holds the switchable bank.

Software writes three registers through a decoded register index. The index names one of two 5-bit bank selects or the mode register, and the write lands on the clock edge where the write strobe is high. The address-to-bank path is purely combinational, so a new CPU address is translated in the same cycle. The fixed banks are derived from a ROM size parameter. The RAM decode covers one 4 KiB window. A 2 KiB device placed in that window appears twice.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset both bank selects and the swap flag are zero, so $8000 and $A000 map bank 0 and $C000 maps bank ROM_BANKS-2.
- R2: Any address in $E000-$FFFF maps bank ROM_BANKS-1, whatever the registers hold.
- R3: Addresses in $A000-$BFFF map the value of bank select B (register index 1).
- R4: With the swap flag clear, $8000-$9FFF maps bank select A (register index 0) and $C000-$DFFF maps bank ROM_BANKS-2.
- R5: With the swap flag set, $8000-$9FFF maps bank ROM_BANKS-2 and $C000-$DFFF maps bank select A.
- R6: A write to register index 2 loads the swap flag from write-data bit 1. All other data bits are ignored.
- R7: A write to index 0 or index 1 loads write-data bits 4:0 into that bank select. Bits 7:5 are ignored.
- R8: Registers change only on a clock edge where wr_en is high. A write to index 3, or a cycle with wr_en low, leaves every register unchanged.
- R9: ram_ce is high exactly for addresses $6000-$6FFF. $7000-$7FFF and everything below $6000 leave it low.
- R10: rom_ce is high exactly when address bit 15 is set. While rom_ce is low, rom_bank reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Decoded register index: 0 bank A, 1 bank B, 2 mode, 3 none |
| wr_data | input | 8 | Register write data |
| rom_bank | output | $clog2(ROM_BANKS) | 8 KiB ROM bank number (upper ROM address bits) |
| rom_ce | output | 1 | ROM chip enable |
| ram_ce | output | 1 | RAM chip enable |

## Verification
The bench probes both lower ROM windows under each state of the swap flag. A mapper that swapped the wrong window, or never swapped at all, would therefore return the second-to-last bank where the select value belongs. Writes carry junk in the ignored upper data bits and in the bits next to the mode flag, so a design that decoded the wrong bit or stored too many bits would show a changed bank. Writes with the strobe low and writes to the unused index must leave every window unchanged. The RAM edges $6FFF, $6800, $7000 and $5FFF catch a decode that takes the full 8 KiB range or drops the upper mirror.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int SEL_W    = 5;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 16;
  localparam int SWAP_BIT = 1;

  typedef enum logic [1:0] {
    IDX_BANK_A = 2'd0,
    IDX_BANK_B = 2'd1,
    IDX_MODE   = 2'd2,
    IDX_NONE   = 2'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    WIN_LOW  = 2'd0,  // $8000-$9FFF
    WIN_MID  = 2'd1,  // $A000-$BFFF
    WIN_HIGH = 2'd2,  // $C000-$DFFF
    WIN_TOP  = 2'd3   // $E000-$FFFF
  } rom_win_e;

  // Bank counted back from the end of the ROM (1 = last bank).
  function automatic int bank_from_end(int banks, int back);
    return banks - back;
  endfunction

  // RAM window: upper address nibble equal to 6.
  function automatic logic in_ram_window(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:12] == 4'h6;
  endfunction
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  bank_a,
  output logic [SEL_W-1:0]  bank_b,
  output logic              swap
);
  reg_idx_e idx;
  logic ld_a, ld_b, ld_mode;

  assign idx     = reg_idx_e'(wr_idx);
  assign ld_a    = wr_en && (idx == IDX_BANK_A);
  assign ld_b    = wr_en && (idx == IDX_BANK_B);
  assign ld_mode = wr_en && (idx == IDX_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_a <= '0;
      bank_b <= '0;
      swap   <= 1'b0;
    end else begin
      if (ld_a)    bank_a <= wr_data[SEL_W-1:0];
      if (ld_b)    bank_b <= wr_data[SEL_W-1:0];
      if (ld_mode) swap   <= wr_data[SWAP_BIT];
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({bank_a, bank_b, swap})); // R8
  AST_IDX_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 2'd3) |=> $stable({bank_a, bank_b, swap})); // R8
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mode |=> swap == $past(wr_data[1])); // R6
  AST_BANK_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> bank_a == $past(wr_data[4:0])); // R7
  AST_BANK_B_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_b |=> bank_b == $past(wr_data[4:0])); // R7
endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
  import prg_map_pkg::*;
(
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              rom_ce,
  output logic              ram_ce,
  output rom_win_e          win
);
  assign rom_ce = cpu_addr[ADDR_W-1];
  assign ram_ce = in_ram_window(cpu_addr);
  assign win    = rom_win_e'(cpu_addr[14:13]);
endmodule

// File: rtl/prg_bank_select.sv
module prg_bank_select
  import prg_map_pkg::*;
#(
  parameter int ROM_BANKS = 32,
  localparam int BANK_W   = $clog2(ROM_BANKS)
) (
  input  logic              rom_ce,
  input  rom_win_e          win,
  input  logic [SEL_W-1:0]  bank_a,
  input  logic [SEL_W-1:0]  bank_b,
  input  logic              swap,
  output logic [BANK_W-1:0] bank
);
  localparam logic [BANK_W-1:0] LAST_BANK   = BANK_W'(bank_from_end(ROM_BANKS, 1));
  localparam logic [BANK_W-1:0] PENULT_BANK = BANK_W'(bank_from_end(ROM_BANKS, 2));

  logic [BANK_W-1:0] sel_a, sel_b;
  assign sel_a = bank_a[BANK_W-1:0];
  assign sel_b = bank_b[BANK_W-1:0];

  always_comb begin
    bank = '0;
    if (rom_ce) begin
      unique case (win)
        WIN_LOW:  bank = swap ? PENULT_BANK : sel_a;
        WIN_MID:  bank = sel_b;
        WIN_HIGH: bank = swap ? sel_a : PENULT_BANK;
        WIN_TOP:  bank = LAST_BANK;
        default:  bank = '0;
      endcase
    end
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ROM_BANKS = 32,
  localparam int BANK_W   = $clog2(ROM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [7:0]        wr_data,
  output logic [BANK_W-1:0] rom_bank,
  output logic              rom_ce,
  output logic              ram_ce
);
  localparam logic [BANK_W-1:0] LAST_CHK   = BANK_W'(ROM_BANKS - 1);
  localparam logic [BANK_W-1:0] PENULT_CHK = BANK_W'(ROM_BANKS - 2);

  logic [SEL_W-1:0] bank_a, bank_b;
  logic             swap;
  rom_win_e         win;

  prg_bank_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .bank_a(bank_a), .bank_b(bank_b), .swap(swap)
  );

  prg_window_decode u_dec (
    .cpu_addr(cpu_addr), .rom_ce(rom_ce), .ram_ce(ram_ce), .win(win)
  );

  prg_bank_select #(.ROM_BANKS(ROM_BANKS)) u_sel (
    .rom_ce(rom_ce), .win(win), .bank_a(bank_a), .bank_b(bank_b),
    .swap(swap), .bank(rom_bank)
  );

  AST_TOP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (rom_bank == LAST_CHK)); // R2
  AST_MID_FOLLOWS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b101) |-> (rom_bank == bank_b[BANK_W-1:0])); // R3
  AST_SWAP_CLR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap && cpu_addr[15:13] == 3'b110) |-> (rom_bank == PENULT_CHK)); // R4
  AST_SWAP_SET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && cpu_addr[15:13] == 3'b100) |-> (rom_bank == PENULT_CHK)); // R5
  AST_RAM_NOT_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> (!rom_ce && rom_bank == '0)); // R9
  AST_LOW_HALF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> (!rom_ce && rom_bank == '0)); // R10
endmodule

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;

  typedef struct {
    logic [15:0] addr;
    logic        rom;
    logic        ram;
    logic [4:0]  bank;
    string       req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 16'h0000;
  logic wr_en = 0;
  logic [1:0] wr_idx = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic [4:0] rom_bank;
  logic rom_ce, ram_ce;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];
  logic [4:0] m_a = 0, m_b = 0;
  logic m_swap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_mapper #(.ROM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rom_bank(rom_bank),
    .rom_ce(rom_ce), .ram_ce(ram_ce)
  );

  function automatic exp_t model(logic [15:0] a, string req);
    exp_t e;
    e.addr = a; e.req = req; e.bank = 0;
    e.rom = (a >= 16'h8000);
    e.ram = (a >= 16'h6000) && (a <= 16'h6FFF);
    if (a >= 16'hE000)      e.bank = 5'(NB - 1);
    else if (a >= 16'hC000) e.bank = m_swap ? m_a : 5'(NB - 2);
    else if (a >= 16'hA000) e.bank = m_b;
    else if (a >= 16'h8000) e.bank = m_swap ? 5'(NB - 2) : m_a;
    return e;
  endfunction

  task automatic probe(logic [15:0] a, string req);
    @(negedge clk);
    cpu_addr = a;
    q.push_back(model(a, req));
  endtask

  task automatic write_reg(logic en, logic [1:0] idx, logic [7:0] d);
    @(negedge clk);
    wr_en = en; wr_idx = idx; wr_data = d;
    if (en) begin
      case (idx)
        2'd0: m_a = d[4:0];
        2'd1: m_b = d[4:0];
        2'd2: m_swap = d[1];
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 0; wr_idx = 2'd3;
  endtask

  task automatic sweep(string req);
    probe(16'h8000, req); probe(16'h9FFF, req);
    probe(16'hA000, req); probe(16'hBFFF, req);
    probe(16'hC000, req); probe(16'hDFFF, req);
    probe(16'hE000, req); probe(16'hFFFF, req);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(posedge clk); #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rom_ce !== e.rom || ram_ce !== e.ram || rom_bank !== e.bank) begin
          errors++;
          $display("FAIL %s addr=%h actual rom_ce=%b ram_ce=%b bank=%0d expected rom_ce=%b ram_ce=%b bank=%0d",
                   e.req, e.addr, rom_ce, ram_ce, rom_bank, e.rom, e.ram, e.bank);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("R1");                         // reset state across all windows
    probe(16'hE123, "R2");
    write_reg(1, 2'd0, 8'hE5);           // R7: upper bits ignored -> 5
    write_reg(1, 2'd1, 8'h3C);           // R7: -> 0x1C
    sweep("R4");
    probe(16'hA800, "R3");
    probe(16'hFABC, "R2");
    write_reg(1, 2'd2, 8'h02);           // R6: swap set
    sweep("R5");
    write_reg(1, 2'd2, 8'hFD);           // R6: bit1 clear, others set
    sweep("R6");
    write_reg(0, 2'd0, 8'h09);           // R8: strobe low
    write_reg(0, 2'd2, 8'h02);           // R8: strobe low on mode
    write_reg(1, 2'd3, 8'hFF);           // R8: unused index
    sweep("R8");
    write_reg(1, 2'd0, 8'h1F);
    write_reg(1, 2'd1, 8'h00);
    sweep("R7");
    write_reg(1, 2'd2, 8'h06);           // swap set again with junk bits
    sweep("R5");
    probe(16'h6000, "R9"); probe(16'h67FF, "R9");
    probe(16'h6800, "R9"); probe(16'h6FFF, "R9");
    probe(16'h7000, "R9"); probe(16'h7FFF, "R10");
    probe(16'h5FFF, "R9"); probe(16'h0000, "R10");
    probe(16'h8001, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule